// File: doc/BRIEF.md
# Bidirectional Cascadable Row-Scan Sequencer

This block generates the row-select pattern for one slice of a thin-film display's row driver. A single active token walks across `ROWS` row outputs, one step per rising edge of the shift clock. A frame begins when the active-low start input is sampled low. A direction pin selects whether the token walks from the low-numbered row upward or from the top row downward. Two mode pins shape how long each row stays selected: one period, two adjacent periods, or two periods with one gap between them. A fourth setting forces every row inactive.

Two slices can share one start pulse and one shift clock to drive a taller panel. No carry wire runs between the slices. Each slice decodes its place in the pair from its chain-select pin and its direction pin. The second slice counts `ROWS` shift clocks after the start pulse before it begins its own scan, so its first row follows straight on from the first slice's last row. All ports are plain control pins. There is no streaming data path, so there is no valid/ready handshake and no back-pressure.

Top module: `gate_scan_seq`

## Requirements
- R1: With `dir_fwd`=1, the token walks from `rows[0]` up to `rows[ROWS-1]`. With `dir_fwd`=0, it walks from `rows[ROWS-1]` down to `rows[0]`. Step n of a scan (n = 0, 1, ...) appears on the outputs after rising edge k+1+n, where k is the edge that loaded the scan. The scan advances one row per edge.
- R2: With mode pins {`mode_a`,`mode_b`} = 2'b11 (single-pulse), exactly the row at the current step is active. At most one output is ever high.
- R3: With mode pins = 2'b01 (continuous double-pulse), row n is active at steps n and n+1. Neighbouring rows therefore overlap by one period.
- R4: With mode pins = 2'b10 (jumping double-pulse), row n is active at steps n and n+2, and inactive at step n+1.
- R5: With mode pins = 2'b00, every output is low from the next edge onward. The scan keeps advancing underneath, so restoring a scanning mode shows the row the scan has reached.
- R6: The slice is first in the pair when `chain_sel` equals `dir_fwd`, and second otherwise. A first slice loads step 0 on the start edge k. A second slice loads step 0 on edge k+`ROWS`, so its step n shows after edge k+`ROWS`+1+n.
- R7: `start_n` is active low and sampled on the rising edge of `clk`. A scan is loaded only on an edge that samples it low after it was sampled high. Holding it low for several edges starts one scan only.
- R8: A new start pulse during a scan, including during a second slice's countdown, discards the scan in flight and restarts from step 0.
- R9: Synchronous active-high `rst` clears the token chain, the cascade countdown and all outputs, which are low after the first edge with `rst` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; every register moves on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_n | input | 1 | Active-low frame start pulse |
| dir_fwd | input | 1 | Scan direction: 1 = upward, 0 = downward |
| chain_sel | input | 1 | Chain position select, decoded together with `dir_fwd` |
| mode_a | input | 1 | Mode select, upper bit |
| mode_b | input | 1 | Mode select, lower bit |
| rows | output | ROWS | Registered row-select outputs, 1 = selected |

## Verification
The hardest state to reach from the ports is the second slice's countdown. A start pulse has to arrive while the internal counter is partway through its `ROWS`-clock wait, and the countdown must also be seen to reach its exact end. The bench runs a second-slice scan for a hundred clocks, sends a new start pulse, and then follows the whole delayed scan. That scan only matches if the earlier countdown was discarded and the new one released step 0 on edge k+`ROWS`.

A second hard case is switching modes in the middle of a scan. The bench does this to show that the all-off setting hides the token without stopping it.

// File: rtl/gss_pkg.sv
`timescale 1ns/1ps
package gss_pkg;
  // Encoding of the two mode pins {mode_a, mode_b}
  typedef enum logic [1:0] {
    SCAN_OFF    = 2'b00,
    SCAN_CONT   = 2'b01,
    SCAN_JUMP   = 2'b10,
    SCAN_SINGLE = 2'b11
  } scan_mode_e;
endpackage

// File: rtl/gss_cascade_timer.sv
`timescale 1ns/1ps
// Counts the wait of a second-position slice: fires ROWS edges after arm.
module gss_cascade_timer #(
  parameter int ROWS = 240
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic fire
);
  localparam int CW = (ROWS > 2) ? $clog2(ROWS) : 1;

  logic          armed;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (arm) begin
      armed <= 1'b1;
      cnt   <= CW'(ROWS - 1);
    end else if (armed) begin
      if (cnt == '0) armed <= 1'b0;
      else           cnt   <= cnt - 1'b1;
    end
  end

  assign fire = armed && (cnt == '0);

  // R6
  fire_once_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && !arm) |=> !fire);

  // R8
  rearm_chk: assert property (@(posedge clk) disable iff (rst)
    arm |=> !fire);
endmodule

// File: rtl/gss_token_chain.sv
`timescale 1ns/1ps
// Logical token chain: stage 0 is the first row of a scan in either direction.
module gss_token_chain #(
  parameter int LEN = 242
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clear,
  input  logic           inject,
  output logic [LEN-1:0] tok
);
  always_ff @(posedge clk) begin
    if (rst)        tok <= '0;
    else if (clear) tok <= {{(LEN-1){1'b0}}, inject};
    else            tok <= {tok[LEN-2:0], inject};
  end

  // R2
  single_token_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tok));

  // R8
  restart_load_chk: assert property (@(posedge clk) disable iff (rst)
    (clear && inject) |=> (tok[0] && $countones(tok) == 1));

  // R1
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    (!clear && tok[0]) |=> tok[1]);
endmodule

// File: rtl/gss_row_shaper.sv
`timescale 1ns/1ps
// Applies the pulse-shape mode and the direction map, then registers the rows.
module gss_row_shaper
  import gss_pkg::*;
#(
  parameter int ROWS = 240
) (
  input  logic            clk,
  input  logic            rst,
  input  scan_mode_e      mode,
  input  logic            fwd,
  input  logic [ROWS+1:0] tok,
  output logic [ROWS-1:0] rows
);
  logic [ROWS-1:0] act;
  logic [ROWS-1:0] phys;

  for (genvar j = 0; j < ROWS; j++) begin : g_row
    assign act[j] = ((mode == SCAN_SINGLE) && tok[j])
                  | ((mode == SCAN_CONT)   && (tok[j] || tok[j+1]))
                  | ((mode == SCAN_JUMP)   && (tok[j] || tok[j+2]));
    assign phys[j] = fwd ? act[j] : act[ROWS-1-j];
  end

  always_ff @(posedge clk) begin
    if (rst) rows <= '0;
    else     rows <= phys;
  end

  // R5
  off_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == SCAN_OFF) |=> (rows == '0));

  // R2
  single_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == SCAN_SINGLE) |=> $onehot0(rows));

  // R3
  double_max_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == SCAN_CONT || mode == SCAN_JUMP) |=> ($countones(rows) <= 2));
endmodule

// File: rtl/gate_scan_seq.sv
`timescale 1ns/1ps
module gate_scan_seq
  import gss_pkg::*;
#(
  parameter int ROWS = 240
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_n,
  input  logic            dir_fwd,
  input  logic            chain_sel,
  input  logic            mode_a,
  input  logic            mode_b,
  output logic [ROWS-1:0] rows
);
  localparam int LEN = ROWS + 2;

  logic           start_q;
  logic           load;
  logic           first_pos;
  logic           fire;
  logic           inject;
  logic [LEN-1:0] tok;
  scan_mode_e     mode;

  always_ff @(posedge clk) begin
    if (rst) start_q <= 1'b1;
    else     start_q <= start_n;
  end

  assign load      = !start_n && start_q;
  assign first_pos = (chain_sel == dir_fwd);
  assign inject    = first_pos ? load : (fire && !load);
  assign mode      = scan_mode_e'({mode_a, mode_b});

  gss_cascade_timer #(.ROWS(ROWS)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .arm  (load && !first_pos),
    .fire (fire)
  );

  gss_token_chain #(.LEN(LEN)) u_chain (
    .clk    (clk),
    .rst    (rst),
    .clear  (load),
    .inject (inject),
    .tok    (tok)
  );

  gss_row_shaper #(.ROWS(ROWS)) u_shaper (
    .clk  (clk),
    .rst  (rst),
    .mode (mode),
    .fwd  (dir_fwd),
    .tok  (tok),
    .rows (rows)
  );

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (rows == '0));

  // R6
  second_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !first_pos) |=> (tok == '0));

  // R7
  held_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!start_n && !start_q) |-> !load);
endmodule

// File: tb/test_gate_scan_seq.sv
`timescale 1ns/1ps
module test_gate_scan_seq;
  localparam int ROWS = 240;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start_n = 1'b1;
  logic            dir_fwd = 1'b1;
  logic            chain_sel = 1'b1;
  logic            mode_a = 1'b1;
  logic            mode_b = 1'b1;
  logic [ROWS-1:0] rows;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  gate_scan_seq #(.ROWS(ROWS)) i_gate_scan_seq (
    .clk       (clk),
    .rst       (rst),
    .start_n   (start_n),
    .dir_fwd   (dir_fwd),
    .chain_sel (chain_sel),
    .mode_a    (mode_a),
    .mode_b    (mode_b),
    .rows      (rows)
  );

  // md: 0 single (pins 11), 1 jumping (10), 2 continuous (01), 3 off (00)
  task automatic set_mode(input int md);
    case (md)
      0: {mode_a, mode_b} = 2'b11;
      1: {mode_a, mode_b} = 2'b10;
      2: {mode_a, mode_b} = 2'b01;
      default: {mode_a, mode_b} = 2'b00;
    endcase
  endtask

  function automatic logic [ROWS-1:0] model(input int t, input bit fwd, input int md);
    logic [ROWS-1:0] v;
    v = '0;
    for (int j = 0; j < ROWS; j++) begin
      bit a;
      a = ((md != 3) && (t == j)) || ((md == 2) && (t == j + 1)) ||
          ((md == 1) && (t == j + 2));
      if (a) v[fwd ? j : ROWS - 1 - j] = 1'b1;
    end
    return v;
  endfunction

  task automatic check(input string tag, input logic [ROWS-1:0] got,
                       input logic [ROWS-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Pulses start low for 'hold' edges, then checks 'cycles' edges.
  task automatic run_scan(input bit fwd, input bit ce, input int md, input int hold,
                          input int cycles, input int off_from, input int off_to,
                          input string tag);
    bit second;
    int e;
    second = (ce != fwd);
    @(negedge clk);
    dir_fwd = fwd; chain_sel = ce; set_mode(md);
    start_n = 1'b0;
    repeat (hold) @(posedge clk);
    @(negedge clk);
    start_n = 1'b1;
    e = hold - 1;
    for (int c = 0; c < cycles; c++) begin
      bit off;
      int t;
      off = (e >= off_from) && (e < off_to);
      set_mode(off ? 3 : md);
      @(posedge clk);
      @(negedge clk);
      e++;
      t = second ? (e - 1 - ROWS) : (e - 1);
      check(tag, rows, off ? '0 : model(t, fwd, md));
    end
    set_mode(md);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset state", rows, '0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 idle after reset", rows, '0);
  endtask

  task automatic t_reset_mid_scan;
    run_scan(1'b1, 1'b1, 0, 1, 20, -1, -1, "R9 pre-reset scan");
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R9 reset mid scan", rows, '0);
    rst = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R9 chain cleared", rows, '0);
    end
  endtask

  initial begin
    t_reset();
    run_scan(1'b1, 1'b1, 0, 1, ROWS + 4, -1, -1, "R1 R2 single upward first");
    run_scan(1'b0, 1'b0, 0, 1, ROWS + 4, -1, -1, "R1 single downward first");
    run_scan(1'b1, 1'b1, 2, 1, ROWS + 4, -1, -1, "R3 continuous upward");
    run_scan(1'b0, 1'b0, 1, 1, ROWS + 4, -1, -1, "R4 jumping downward");
    run_scan(1'b1, 1'b1, 1, 1, 30, -1, -1, "R4 jumping upward");
    run_scan(1'b1, 1'b1, 0, 1, 40, 10, 16, "R5 off window mid scan");
    run_scan(1'b1, 1'b0, 0, 1, 2 * ROWS + 4, -1, -1, "R6 second upward");
    run_scan(1'b0, 1'b1, 2, 1, 2 * ROWS + 4, -1, -1, "R6 second downward continuous");
    run_scan(1'b1, 1'b1, 0, 4, 60, -1, -1, "R7 start held low");
    run_scan(1'b1, 1'b1, 0, 1, 50, -1, -1, "R8 first scan");
    run_scan(1'b1, 1'b1, 0, 1, 80, -1, -1, "R8 restart first");
    run_scan(1'b1, 1'b0, 0, 1, 100, -1, -1, "R8 second countdown");
    run_scan(1'b1, 1'b0, 0, 1, 2 * ROWS + 4, -1, -1, "R8 restart second");
    t_reset_mid_scan();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule